// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the fetch address for a small 8-bit controller whose program memory holds 16-bit words. A 12-bit program counter advances once per instruction cycle. An instruction cycle is one pulse of an internal enable that fires every fourth clock. In each cycle the decoder picks one operation on `op_i`. It can let the counter step forward, load a jump or call target, take an interrupt, return from a subroutine or from an interrupt, or replace or offset the low byte of the counter.

Subroutine and interrupt return addresses go into a four-entry circular stack. Its write pointer is visible on the ports. A sticky flag marks that a push found the stack already full. The low byte of the counter acts as the index inside a 256-word page. Writing it or adding to it never changes the page bits, so a table index that passes xxFFH lands at xx00H of the same page. A watchdog reset clears the block in the same way as the external reset.

Top module: `pc_sequencer`

## Requirements
- R1: Asynchronous reset (`rst_n` low), or a synchronous watchdog reset (`wdt_rst_i` high at a clock edge), sets the fetch address to 0000H, the stack pointer to 0, the stack entries to 0 and the overflow flag to 0.
- R2: The counter changes only at a clock edge where `step_o` is high. `step_o` is high for one clock in every four, and the first such edge is the fourth edge after reset. `op_i` is sampled at that edge. Its codes are: 0 step, 1 jump, 2 call, 3 return, 4 return-from-interrupt, 5 interrupt entry, 6 low-byte write, 7 low-byte add.
- R3: Op 0 adds one to the full counter, so 0FFH is followed by 100H.
- R4: Op 1 loads `target_i` into the counter.
- R5: Op 2 pushes the counter plus one and loads `target_i`. Op 3 pops the top entry into the counter.
- R6: Op 5 pushes the current counter unchanged and loads 0008H.
- R7: Op 4 pops like op 3 and also raises `gie_set_o` for exactly one clock.
- R8: Op 6 replaces bits 7..0 of the counter with `pcl_val_i` and keeps the upper bits.
- R9: Op 7 adds `pcl_val_i` to bits 7..0 modulo 256, drops the carry and keeps the upper bits.
- R10: The stack holds four entries and is last-in first-out. Each push increments the pointer modulo 4. A fifth push in a row overwrites the oldest entry and sets `stk_ovf_o`, which stays set until reset.
- R11: A pop with the pointer at 0 wraps the pointer to 3 and loads the entry in slot 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdt_rst_i | input | 1 | Synchronous watchdog reset, active high |
| op_i | input | 3 | Operation for the current instruction cycle |
| target_i | input | PC_W (12) | Jump or call target |
| pcl_val_i | input | 8 | Low-byte write value or add operand |
| fetch_addr_o | output | PC_W (12) | Current program counter |
| stk_ptr_o | output | 2 | Stack write pointer |
| stk_ovf_o | output | 1 | Sticky stack overflow flag |
| gie_set_o | output | 1 | One-clock pulse that re-enables interrupts |
| step_o | output | 1 | Instruction-cycle enable |

## Verification
The assertions check the following on every cycle:
- the counter holds still between enable pulses;
- interrupt entry always lands on 0008H;
- low-byte writes and adds never disturb the page bits;
- the interrupt re-enable pulse lasts one clock;
- the enable never fires on two clocks in a row;
- each push advances the pointer by one;
- the overflow flag never drops outside reset.

Only the directed scenarios can show what the stored return addresses are. These scenarios cover call and interrupt nesting, the overwrite of the oldest entry, the wrap of the pointer on an empty pop, the page wrap of a table index, and the counter stepping across a page boundary.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
    typedef enum logic [2:0] {
        OP_STEP    = 3'd0,
        OP_JUMP    = 3'd1,
        OP_CALL    = 3'd2,
        OP_RET     = 3'd3,
        OP_RETI    = 3'd4,
        OP_IRQ     = 3'd5,
        OP_PCL_WR  = 3'd6,
        OP_PCL_ADD = 3'd7
    } pc_op_e;

    localparam int PAGE_W = 8;
endpackage

// File: rtl/pc_cycle_div.sv
module pc_cycle_div #(
    parameter int CYC_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic step_o
);
    localparam int CNT_W = (CYC_DIV > 2) ? $clog2(CYC_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_s;

    div_s div_d, div_q;

    assign step_o = (div_q.cnt == LAST);

    always_comb begin
        div_d = div_q;
        if (clr_i || step_o) div_d.cnt = '0;
        else                 div_d.cnt = div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R2: the enable is never high on two consecutive clocks
    a_r2_step_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic [W-1:0]             push_data_i,
    output logic [W-1:0]             top_o,
    output logic [$clog2(DEPTH)-1:0] sp_o,
    output logic                     ovf_o
);
    // DEPTH must be a power of two so that the pointer wraps on its own
    localparam int SP_W  = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [SP_W-1:0]         sp;
        logic [CNT_W-1:0]        fill;
        logic                    ovf;
    } stk_s;

    stk_s stk_d, stk_q;
    logic [SP_W-1:0] rd_idx;

    assign rd_idx = stk_q.sp - 1'b1;
    assign top_o  = stk_q.mem[rd_idx];
    assign sp_o   = stk_q.sp;
    assign ovf_o  = stk_q.ovf;

    always_comb begin
        stk_d = stk_q;
        if (clr_i) begin
            stk_d = '0;
        end else if (push_i) begin
            stk_d.mem[stk_q.sp] = push_data_i;
            stk_d.sp            = stk_q.sp + 1'b1;
            if (stk_q.fill == FULL) stk_d.ovf  = 1'b1;
            else                    stk_d.fill = stk_q.fill + 1'b1;
        end else if (pop_i) begin
            stk_d.sp = rd_idx;
            if (stk_q.fill != '0) stk_d.fill = stk_q.fill - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    a_r10_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clr_i) |=> (sp_o == SP_W'($past(sp_o) + 1'b1)));

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);

    a_r11_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !clr_i) |=> (sp_o == SP_W'($past(sp_o) - 1'b1)));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int PC_W    = 12,
    parameter int DEPTH   = 4,
    parameter int CYC_DIV = 4,
    parameter int IRQ_VEC = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wdt_rst_i,
    input  logic [2:0]               op_i,
    input  logic [PC_W-1:0]          target_i,
    input  logic [PAGE_W-1:0]        pcl_val_i,
    output logic [PC_W-1:0]          fetch_addr_o,
    output logic [$clog2(DEPTH)-1:0] stk_ptr_o,
    output logic                     stk_ovf_o,
    output logic                     gie_set_o,
    output logic                     step_o
);
    localparam int HI_W = PC_W - PAGE_W;
    localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            gie;
    } seq_s;

    seq_s seq_d, seq_q;
    pc_op_e op;
    logic push, pop;
    logic [PC_W-1:0] push_data, stk_top, pc_inc;
    logic [PAGE_W-1:0] pcl_sum;

    assign op      = pc_op_e'(op_i);
    assign pc_inc  = seq_q.pc + 1'b1;
    assign pcl_sum = seq_q.pc[PAGE_W-1:0] + pcl_val_i;

    pc_cycle_div #(.CYC_DIV(CYC_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (wdt_rst_i),
        .step_o (step_o)
    );

    pc_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (wdt_rst_i),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .top_o       (stk_top),
        .sp_o        (stk_ptr_o),
        .ovf_o       (stk_ovf_o)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.gie = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = pc_inc;
        if (wdt_rst_i) begin
            seq_d = '0;
        end else if (step_o) begin
            unique case (op)
                OP_STEP:   seq_d.pc = pc_inc;
                OP_JUMP:   seq_d.pc = target_i;
                OP_CALL: begin
                    push     = 1'b1;
                    seq_d.pc = target_i;
                end
                OP_RET: begin
                    pop      = 1'b1;
                    seq_d.pc = stk_top;
                end
                OP_RETI: begin
                    pop       = 1'b1;
                    seq_d.pc  = stk_top;
                    seq_d.gie = 1'b1;
                end
                OP_IRQ: begin
                    push      = 1'b1;
                    push_data = seq_q.pc;
                    seq_d.pc  = VEC;
                end
                OP_PCL_WR:  seq_d.pc = {seq_q.pc[PC_W-1:PAGE_W], pcl_val_i};
                OP_PCL_ADD: seq_d.pc = {seq_q.pc[PC_W-1:PAGE_W], pcl_sum};
                default:    seq_d.pc = pc_inc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign fetch_addr_o = seq_q.pc;
    assign gie_set_o    = seq_q.gie;

    a_r2_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_o && !wdt_rst_i) |=> $stable(fetch_addr_o));

    a_r6_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !wdt_rst_i && op_i == 3'd5) |=> (fetch_addr_o == VEC));

    a_r8_r9_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !wdt_rst_i && (op_i == 3'd6 || op_i == 3'd7)) |=>
        (fetch_addr_o[PC_W-1:PAGE_W] == $past(fetch_addr_o[PC_W-1:PAGE_W])));

    a_r7_gie_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        gie_set_o |=> !gie_set_o);

    a_r1_wdt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_i |=> (fetch_addr_o == '0 && stk_ptr_o == '0 && !stk_ovf_o));

    initial begin
        a_page_fits: assert (HI_W > 0);
    end
endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt_rst_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [11:0] target_i = '0;
    logic [7:0]  pcl_val_i = '0;
    logic [11:0] fetch_addr_o;
    logic [1:0]  stk_ptr_o;
    logic        stk_ovf_o, gie_set_o, step_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .wdt_rst_i(wdt_rst_i), .op_i(op_i),
        .target_i(target_i), .pcl_val_i(pcl_val_i),
        .fetch_addr_o(fetch_addr_o), .stk_ptr_o(stk_ptr_o),
        .stk_ovf_o(stk_ovf_o), .gie_set_o(gie_set_o), .step_o(step_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one operation, let it take effect, return on the next falling edge
    task automatic do_op(input logic [2:0] op, input logic [11:0] tgt, input logic [7:0] v);
        op_i = op; target_i = tgt; pcl_val_i = v;
        while (step_o !== 1'b1) @(negedge clk);
        @(negedge clk);
        op_i = 3'd0;
    endtask

    task automatic wdt_pulse();
        @(negedge clk);
        wdt_rst_i = 1'b1;
        @(negedge clk);
        wdt_rst_i = 1'b0;
    endtask

    task automatic t_reset_and_timing();
        check("R1 pc after reset", fetch_addr_o, 0);
        check("R1 sp after reset", stk_ptr_o, 0);
        check("R1 ovf after reset", stk_ovf_o, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 held before enable", fetch_addr_o, 0);
        end
        @(negedge clk);
        check("R2 advance on fourth edge", fetch_addr_o, 1);
        check("R3 step from 0", fetch_addr_o, 1);
    endtask

    task automatic t_jump_and_increment();
        do_op(3'd1, 12'h0FE, 8'h00);
        check("R4 jump", fetch_addr_o, 12'h0FE);
        do_op(3'd0, 12'h000, 8'h00);
        check("R3 step", fetch_addr_o, 12'h0FF);
        do_op(3'd0, 12'h000, 8'h00);
        check("R3 step across page", fetch_addr_o, 12'h100);
    endtask

    task automatic t_call_return();
        do_op(3'd2, 12'h234, 8'h00);
        check("R5 call target", fetch_addr_o, 12'h234);
        check("R5 call sp", stk_ptr_o, 1);
        do_op(3'd3, 12'h000, 8'h00);
        check("R5 return address", fetch_addr_o, 12'h101);
        check("R5 return sp", stk_ptr_o, 0);
    endtask

    task automatic t_irq_reti();
        do_op(3'd1, 12'h055, 8'h00);
        do_op(3'd5, 12'hFFF, 8'h00);
        check("R6 irq vector", fetch_addr_o, 12'h008);
        check("R6 irq sp", stk_ptr_o, 1);
        check("R7 no gie on irq", gie_set_o, 0);
        do_op(3'd4, 12'h000, 8'h00);
        check("R7 reti address", fetch_addr_o, 12'h055);
        check("R7 gie pulse", gie_set_o, 1);
        @(negedge clk);
        check("R7 gie one clock", gie_set_o, 0);
    endtask

    task automatic t_pcl_ops();
        do_op(3'd1, 12'h3A7, 8'h00);
        do_op(3'd6, 12'hFFF, 8'h12);
        check("R8 low byte write", fetch_addr_o, 12'h312);
        do_op(3'd1, 12'h2FD, 8'h00);
        do_op(3'd7, 12'h000, 8'h03);
        check("R9 add wraps in page", fetch_addr_o, 12'h200);
        do_op(3'd7, 12'h000, 8'h01);
        check("R9 add plain", fetch_addr_o, 12'h201);
    endtask

    task automatic t_overflow();
        wdt_pulse();
        check("R1 wdt pc", fetch_addr_o, 0);
        do_op(3'd1, 12'h010, 8'h00);
        for (int k = 1; k <= 5; k++) begin
            do_op(3'd2, 12'(k * 12'h100), 8'h00);
            if (k == 4) check("R10 no ovf at four", stk_ovf_o, 0);
        end
        check("R10 ovf set", stk_ovf_o, 1);
        check("R10 sp wrapped", stk_ptr_o, 1);
        do_op(3'd3, 12'h000, 8'h00);
        check("R10 lifo 1", fetch_addr_o, 12'h401);
        do_op(3'd3, 12'h000, 8'h00);
        check("R10 lifo 2", fetch_addr_o, 12'h301);
        check("R10 sp wrap down", stk_ptr_o, 3);
        do_op(3'd3, 12'h000, 8'h00);
        check("R10 lifo 3", fetch_addr_o, 12'h201);
        do_op(3'd3, 12'h000, 8'h00);
        check("R10 lifo 4", fetch_addr_o, 12'h101);
        do_op(3'd3, 12'h000, 8'h00);
        check("R10 oldest overwritten", fetch_addr_o, 12'h401);
        check("R10 ovf sticky", stk_ovf_o, 1);
    endtask

    task automatic t_wdt_and_empty_pop();
        wdt_pulse();
        check("R1 wdt clears ovf", stk_ovf_o, 0);
        check("R1 wdt clears sp", stk_ptr_o, 0);
        do_op(3'd1, 12'h0AB, 8'h00);
        do_op(3'd3, 12'h000, 8'h00);
        check("R11 empty pop sp", stk_ptr_o, 3);
        check("R11 empty pop loads slot 3", fetch_addr_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset_and_timing();
        t_jump_and_increment();
        t_call_return();
        t_irq_reti();
        t_pcl_ops();
        t_overflow();
        t_wdt_and_empty_pop();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule